// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block collects completion and resource events from a tiling graphics engine and presents them to software as a small register file behind a simple read/write strobe bus. Two events are pulses: the binner finishing its flush and the renderer finishing a frame. Each pulse is latched into a pending bit until software acknowledges it. The third event is a level condition. The binner has run out of overflow memory, and that condition holds while the remaining overflow budget is zero. Its pending bit keeps coming back until software supplies a new overflow buffer.

Software never writes the enable mask directly. One register turns enable bits on and a second one turns them off. In both registers a zero bit has no effect, and both read back the same mask. The single interrupt line is the registered OR of pending bits that are also enabled. A down-counter models the binner's use of overflow memory. Writing the size register reloads the counter, and each consume strobe from the binner takes one unit from it.

Top module: `gfxIrqCtl`

## Requirements
- R1: After reset the enable mask, the flush and frame pending bits, the overflow address, the remaining size, `rdData` and `irq` are all zero. Because the size is zero, pending bit 0 (out of memory) is set on the first clock after reset ends.
- R2: A one-cycle pulse on `flushDone` sets pending bit 1, and a pulse on `frameDone` sets pending bit 2. Each bit stays set until software acknowledges it.
- R3: Writing the pending register (word address 0) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: Writing the enable-on register (address 1) sets every mask bit written as 1. Bits written as 0 are unchanged.
- R5: Writing the enable-off register (address 2) clears every mask bit written as 1. Bits written as 0 are unchanged.
- R6: Reading address 1 and reading address 2 both return the current enable mask in bits 2:0, with zeros above.
- R7: `irq` is the OR of (pending AND mask), taken through one register. It changes on the clock edge after the pending bit or mask bit that causes the change.
- R8: If a source pulse arrives in the same cycle as a write-1 acknowledge of its bit, the bit stays set.
- R9: While the remaining size is zero, pending bit 0 reads as 1 even after it is written 1 to acknowledge it.
- R10: Writing address 3 loads the overflow address, which appears on `ovfAddr`. Writing address 4 loads the remaining size, which appears on `ovfSize` and can be read at address 4. Each `binUse` cycle lowers a nonzero size by one. A size write in the same cycle as `binUse` takes priority over the decrement.
- R11: Reads return data on `rdData` one clock after `rdEn`. Addresses 5 to 7 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Word address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid one clock after rdEn |
| flushDone | input | 1 | Binner flush finished, one-cycle pulse |
| frameDone | input | 1 | Render frame finished, one-cycle pulse |
| binUse | input | 1 | Binner consumed one unit of overflow memory |
| irq | output | 1 | Interrupt request to the host |
| ovfAddr | output | 32 | Overflow buffer base address handed to the binner |
| ovfSize | output | 16 | Remaining overflow budget handed to the binner |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is an acknowledge write to the pending register and a new source pulse on the same bit. The second pair is a size write and a `binUse` decrement. The bench drives each pair on the same clock edge, for both the flush bit and the frame bit, and for a size load while `binUse` is high. It then judges the result through a pending-register read, which must show the bit still set, and through the `ovfSize` port, which must show the newly written value with no unit taken off.

// File: rtl/irqCtlPkg.sv
package irqCtlPkg;
  localparam int NUM_SRC   = 3;
  localparam int SRC_OOM   = 0;
  localparam int SRC_FLUSH = 1;
  localparam int SRC_FRAME = 2;

  typedef enum logic [2:0] {
    SEL_STAT    = 3'd0,
    SEL_ENSET   = 3'd1,
    SEL_ENCLR   = 3'd2,
    SEL_OVFADDR = 3'd3,
    SEL_OVFSIZE = 3'd4,
    SEL_NONE    = 3'd7
  } regSel_e;

  typedef struct packed {
    logic [NUM_SRC-1:0] statClr;
    logic [NUM_SRC-1:0] enSet;
    logic [NUM_SRC-1:0] enClr;
    logic               addrLd;
    logic               sizeLd;
    logic               rdEn;
    regSel_e            rdSel;
  } ctlStrb_t;
endpackage

// File: rtl/irqCtlDecode.sv
module irqCtlDecode
  import irqCtlPkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wrBits,
  output ctlStrb_t           strb
);
  localparam logic [ADDR_W-1:0] A_STAT    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ENSET   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ENCLR   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_OVFADDR = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_OVFSIZE = ADDR_W'(4);

  regSel_e sel;

  always_comb begin
    case (addr)
      A_STAT:    sel = SEL_STAT;
      A_ENSET:   sel = SEL_ENSET;
      A_ENCLR:   sel = SEL_ENCLR;
      A_OVFADDR: sel = SEL_OVFADDR;
      A_OVFSIZE: sel = SEL_OVFSIZE;
      default:   sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strb         = '0;
    strb.rdEn    = rdEn;
    strb.rdSel   = sel;
    if (wrEn) begin
      case (sel)
        SEL_STAT:    strb.statClr = wrBits;
        SEL_ENSET:   strb.enSet   = wrBits;
        SEL_ENCLR:   strb.enClr   = wrBits;
        SEL_OVFADDR: strb.addrLd  = 1'b1;
        SEL_OVFSIZE: strb.sizeLd  = 1'b1;
        default:     ;
      endcase
    end
  end

  // R11: a write outside the map raises no strobe
  a_r11_unmapped_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr > A_OVFSIZE) |-> (strb.statClr == '0 && strb.enSet == '0 &&
      strb.enClr == '0 && !strb.addrLd && !strb.sizeLd));
endmodule

// File: rtl/irqCtlRegs.sv
module irqCtlRegs
  import irqCtlPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              flushDone,
  input  logic              frameDone,
  input  logic              binUse,
  output logic              irq,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] ovfAddr,
  output logic [SIZE_W-1:0] ovfSize
);
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] enMask;
  logic [NUM_SRC-1:0] srcIn;
  logic [SIZE_W-1:0]  remainQ;
  logic [DATA_W-1:0]  addrQ;
  logic [DATA_W-1:0]  rdMux;
  logic               oomLevel;

  assign oomLevel         = (remainQ == '0);
  assign srcIn[SRC_OOM]   = oomLevel;
  assign srcIn[SRC_FLUSH] = flushDone;
  assign srcIn[SRC_FRAME] = frameDone;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rstN) begin
        statusQ[i] <= 1'b0;
        enMask[i]  <= 1'b0;
      end else begin
        statusQ[i] <= (statusQ[i] & ~strb.statClr[i]) | srcIn[i];
        if (strb.enSet[i])      enMask[i] <= 1'b1;
        else if (strb.enClr[i]) enMask[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remainQ <= '0;
      addrQ   <= '0;
    end else begin
      if (strb.addrLd) addrQ <= wrData;
      if (strb.sizeLd)             remainQ <= wrData[SIZE_W-1:0];
      else if (binUse && !oomLevel) remainQ <= remainQ - SIZE_W'(1);
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_STAT:              rdMux = DATA_W'(statusQ);
      SEL_ENSET, SEL_ENCLR:  rdMux = DATA_W'(enMask);
      SEL_OVFADDR:           rdMux = addrQ;
      SEL_OVFSIZE:           rdMux = DATA_W'(remainQ);
      default:               rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
      irq    <= 1'b0;
    end else begin
      if (strb.rdEn) rdData <= rdMux;
      irq <= |(statusQ & enMask);
    end
  end

  assign ovfAddr = addrQ;
  assign ovfSize = remainQ;

  // R8: a flush pulse is never lost, even under an acknowledge
  a_r8_flush_kept: assert property (@(posedge clk) disable iff (!rstN)
    flushDone |=> statusQ[SRC_FLUSH]);
  a_r8_frame_kept: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> statusQ[SRC_FRAME]);
  // R9: empty overflow budget keeps the out-of-memory bit pending
  a_r9_oom_sticky: assert property (@(posedge clk) disable iff (!rstN)
    oomLevel |=> statusQ[SRC_OOM]);
  // R7: the request line trails enabled pending bits by one clock
  a_r7_irq_raise: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusQ & enMask)) |=> irq);
  a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(|(statusQ & enMask)) |=> !irq);
  // R4 / R5: set and clear registers touch only the bits written as 1
  a_r4_enable_on: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.enSet) |=> ((enMask & $past(strb.enSet)) == $past(strb.enSet)));
  a_r5_enable_off: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.enClr) |=> ((enMask & $past(strb.enClr)) == '0));
  // R10: draining the last unit raises out-of-memory on the next clock
  a_r10_drain: assert property (@(posedge clk) disable iff (!rstN)
    (remainQ == SIZE_W'(1) && binUse && !strb.sizeLd) |=> ##1 statusQ[SRC_OOM]);
endmodule

// File: rtl/gfxIrqCtl.sv
module gfxIrqCtl
  import irqCtlPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              flushDone,
  input  logic              frameDone,
  input  logic              binUse,
  output logic              irq,
  output logic [DATA_W-1:0] ovfAddr,
  output logic [SIZE_W-1:0] ovfSize
);
  ctlStrb_t strb;

  irqCtlDecode #(.ADDR_W(ADDR_W)) i_decode (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrBits (wrData[NUM_SRC-1:0]),
    .strb   (strb)
  );

  irqCtlRegs #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) i_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .flushDone (flushDone),
    .frameDone (frameDone),
    .binUse    (binUse),
    .irq       (irq),
    .rdData    (rdData),
    .ovfAddr   (ovfAddr),
    .ovfSize   (ovfSize)
  );
endmodule

// File: tb/test_gfxIrqCtl.sv
module test_gfxIrqCtl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        flushDone = 1'b0;
  logic        frameDone = 1'b0;
  logic        binUse = 1'b0;
  logic        irq;
  logic [31:0] ovfAddr;
  logic [15:0] ovfSize;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gfxIrqCtl i_gfxIrqCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .flushDone(flushDone),
    .frameDone(frameDone), .binUse(binUse), .irq(irq),
    .ovfAddr(ovfAddr), .ovfSize(ovfSize)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 rdData after reset", rdData, 32'h0);
    readReg(3'd1, v); check("R1 mask after reset", v, 32'h0);
    readReg(3'd0, v); check("R1 pending after reset (oom only)", v, 32'h1);
    readReg(3'd3, v); check("R1 ovf address after reset", v, 32'h0);
    check("R1 ovfSize port after reset", {16'b0, ovfSize}, 32'h0);
  endtask

  task automatic testOverflow();
    logic [31:0] v;
    writeReg(3'd0, 32'h1);
    readReg(3'd0, v); check("R9 oom bit survives ack", v, 32'h1);
    writeReg(3'd3, 32'hCAFE_0000);
    check("R10 ovfAddr port", ovfAddr, 32'hCAFE_0000);
    readReg(3'd3, v); check("R10 ovf address readback", v, 32'hCAFE_0000);
    writeReg(3'd4, 32'd3);
    check("R10 ovfSize port", {16'b0, ovfSize}, 32'd3);
    writeReg(3'd0, 32'h1);
    readReg(3'd0, v); check("R10 oom clears after size and ack", v, 32'h0);
    @(negedge clk); binUse = 1'b1;
    repeat (3) @(negedge clk);
    binUse = 1'b0;
    check("R10 size drained", {16'b0, ovfSize}, 32'h0);
    readReg(3'd0, v); check("R10 oom returns at zero", v, 32'h1);
    readReg(3'd4, v); check("R10 size readback", v, 32'h0);
    @(negedge clk);
    binUse = 1'b1; wrEn = 1'b1; addr = 3'd4; wrData = 32'd5;
    @(negedge clk);
    binUse = 1'b0; wrEn = 1'b0;
    check("R10 load beats decrement", {16'b0, ovfSize}, 32'd5);
    writeReg(3'd4, 32'd1000);
    writeReg(3'd0, 32'h1);
  endtask

  task automatic testLatch();
    logic [31:0] v;
    @(negedge clk); flushDone = 1'b1;
    @(negedge clk); flushDone = 1'b0;
    repeat (2) @(negedge clk);
    readReg(3'd0, v); check("R2 flush latched", v, 32'h2);
    @(negedge clk); frameDone = 1'b1;
    @(negedge clk); frameDone = 1'b0;
    readReg(3'd0, v); check("R2 frame latched", v, 32'h6);
    writeReg(3'd0, 32'h0);
    readReg(3'd0, v); check("R3 zero write keeps bits", v, 32'h6);
    writeReg(3'd0, 32'h2);
    readReg(3'd0, v); check("R3 clear flush only", v, 32'h4);
    writeReg(3'd0, 32'h4);
    readReg(3'd0, v); check("R3 clear frame", v, 32'h0);
  endtask

  task automatic testEnable();
    logic [31:0] v;
    writeReg(3'd1, 32'h5);
    readReg(3'd1, v); check("R4 set bits 0,2", v, 32'h5);
    readReg(3'd2, v); check("R6 clear register reads mask", v, 32'h5);
    writeReg(3'd1, 32'h0);
    readReg(3'd1, v); check("R4 zero write no effect", v, 32'h5);
    writeReg(3'd2, 32'h1);
    readReg(3'd1, v); check("R5 clear bit 0", v, 32'h4);
    writeReg(3'd2, 32'h0);
    readReg(3'd2, v); check("R5 zero write no effect", v, 32'h4);
  endtask

  task automatic testIrq();
    @(negedge clk); frameDone = 1'b1;
    @(negedge clk); frameDone = 1'b0;
    check("R7 irq one clock late", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R7 irq raised", {31'b0, irq}, 32'h1);
    @(negedge clk); flushDone = 1'b1;
    @(negedge clk); flushDone = 1'b0;
    writeReg(3'd0, 32'h4);
    check("R7 irq held until next clock", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R7 masked flush keeps irq low", {31'b0, irq}, 32'h0);
    writeReg(3'd1, 32'h2);
    @(negedge clk);
    check("R4 enabling pending flush raises irq", {31'b0, irq}, 32'h1);
    writeReg(3'd2, 32'h2);
    @(negedge clk);
    check("R5 disabling drops irq", {31'b0, irq}, 32'h0);
    writeReg(3'd0, 32'h2);
  endtask

  task automatic testCollide();
    logic [31:0] v;
    @(negedge clk);
    flushDone = 1'b1; wrEn = 1'b1; addr = 3'd0; wrData = 32'h2;
    @(negedge clk);
    flushDone = 1'b0; wrEn = 1'b0;
    readReg(3'd0, v); check("R8 flush set beats ack", v, 32'h2);
    @(negedge clk);
    frameDone = 1'b1; wrEn = 1'b1; addr = 3'd0; wrData = 32'h6;
    @(negedge clk);
    frameDone = 1'b0; wrEn = 1'b0;
    readReg(3'd0, v); check("R8 frame set beats ack", v, 32'h4);
    writeReg(3'd0, 32'h4);
    readReg(3'd0, v); check("R8 plain ack still clears", v, 32'h0);
  endtask

  task automatic testUnmapped();
    logic [31:0] v;
    writeReg(3'd7, 32'hFFFF_FFFF);
    writeReg(3'd5, 32'hFFFF_FFFF);
    readReg(3'd1, v); check("R11 unmapped write leaves mask", v, 32'h4);
    readReg(3'd0, v); check("R11 unmapped write leaves pending", v, 32'h0);
    check("R11 unmapped write leaves size", {16'b0, ovfSize}, 32'd1000);
    readReg(3'd7, v); check("R11 unmapped read is zero", v, 32'h0);
    @(negedge clk); rdEn = 1'b1; addr = 3'd1;
    @(posedge clk); #1;
    check("R11 read data after one clock", rdData, 32'h4);
    @(negedge clk); rdEn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testOverflow();
    testLatch();
    testEnable();
    testIrq();
    testCollide();
    testUnmapped();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule